// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Latched Driver

This block turns a serial bit stream into 64 parallel channel levels for a wide bank of output drivers. A direction input picks which of two shared serial pins receives data and which passes data on. The other pin drives out the stage that falls off the end of the register, so identical blocks can be chained. Each pin is modelled as an input, an output and an output-enable. Bit i of the register and of the outputs is channel i+1.

The register moves one stage on every rising clock edge. A 64-bit latch sits behind it. While the latch-enable input is high the latch is transparent and follows the register. When latch-enable falls, the latch keeps the current contents, and the register can then load the next line while the outputs stay steady. The output stage combines a blanking input and a polarity input. Together they select pass-through, inversion, all channels high or all channels low.

Top module: `sipo_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears the register and the latch. With show=1 and keep_pol=1, every channel output and both serial outputs then read 0.
- R2: With fwd=0, pin A is the serial input and enters channel 64 (bit 63), and data moves toward channel 1. Pin B is driven (b_oe=1, a_oe=0) and carries channel 1 (bit 0).
- R3: With fwd=1, pin B is the serial input and enters channel 1 (bit 0), and data moves toward channel 64. Pin A is driven (a_oe=1, b_oe=0) and carries channel 64 (bit 63).
- R4: The register advances exactly one stage on each rising clock edge. Latch-enable, show and keep_pol have no effect on shifting.
- R5: While xparent=1, the latch follows the register contents, including changes made by shifting.
- R6: After xparent falls, the latch keeps the contents it held at the fall while the register continues to shift.
- R7: show=1, keep_pol=1: each channel output equals its latched bit.
- R8: show=1, keep_pol=0: each channel output is the inverse of its latched bit.
- R9: show=0, keep_pol=0: all 64 channel outputs are 1.
- R10: show=0, keep_pol=1: all 64 channel outputs are 0.
- R11: The serial output repeats a bit applied at the serial input exactly 64 clock edges later, so blocks can be cascaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register shifts on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fwd | input | 1 | Shift direction: 0 = toward channel 1, 1 = toward channel 64 |
| a_i | input | 1 | Pin A received level |
| a_o | output | 1 | Pin A driven level (channel 64 stage) |
| a_oe | output | 1 | Pin A output enable |
| b_i | input | 1 | Pin B received level |
| b_o | output | 1 | Pin B driven level (channel 1 stage) |
| b_oe | output | 1 | Pin B output enable |
| xparent | input | 1 | Latch enable: 1 = transparent, falling edge holds |
| show | input | 1 | Blanking control: 0 forces all channels |
| keep_pol | input | 1 | Polarity: 1 = true, 0 = inverted / forced high |
| drv | output | 64 | Channel outputs, bit i = channel i+1 |

## Verification
The hardest case to reach from the ports is a held latch while the register keeps moving underneath it. The register shifts on every edge, with no enable, so a full pattern has to be loaded with latch-enable raised just before the 64th edge and dropped one cycle later. The stimulus does this in one load routine. It then keeps shifting fresh data while it toggles the output modes, and it confirms that the channels still show the captured line and that the cascade pin shows the moving register. Both directions are also walked end to end with a single marker bit, which checks entry, exit and the 64-edge delay.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;

    localparam int unsigned CH_W = 64;

    // output mode selected by {show, keep_pol}
    typedef enum logic [1:0] {
        MODE_ALL_HIGH = 2'b00,
        MODE_ALL_LOW  = 2'b01,
        MODE_INVERT   = 2'b10,
        MODE_PASS     = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic data;
        logic en;
    } pin_drv_t;

    function automatic out_mode_e pick_mode(input logic show, input logic keep_pol);
        return out_mode_e'({show, keep_pol});
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd,
    input  logic         in_low,
    input  logic         in_high,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_lo_end
            assign from_below = in_low;
        end else begin : g_lo_mid
            assign from_below = q[i-1];
        end
        if (i == W - 1) begin : g_hi_end
            assign from_above = in_high;
        end else begin : g_hi_mid
            assign from_above = q[i+1];
        end
        assign nxt[i] = fwd ? from_below : from_above;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/sipo_latch_stage.sv
module sipo_latch_stage #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xparent,
    input  logic [W-1:0] sr_q,
    input  logic [W-1:0] sr_nxt,
    output logic [W-1:0] view
);

    logic [W-1:0] held;

    // held tracks the register's next value while open, so a fall of
    // xparent between edges leaves it equal to the current contents
    always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (xparent) held <= sr_nxt;
    end

    assign view = xparent ? sr_q : held;

endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage
    import sipo_drv_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         show,
    input  logic         keep_pol,
    input  logic [W-1:0] lat,
    output logic [W-1:0] drv
);

    out_mode_e mode;

    assign mode = pick_mode(show, keep_pol);

    always_comb begin
        unique case (mode)
            MODE_PASS:     drv = lat;
            MODE_INVERT:   drv = ~lat;
            MODE_ALL_HIGH: drv = '1;
            MODE_ALL_LOW:  drv = '0;
            default:       drv = '0;
        endcase
    end

endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver
    import sipo_drv_pkg::*;
#(
    parameter int unsigned W = CH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd,
    input  logic         a_i,
    output logic         a_o,
    output logic         a_oe,
    input  logic         b_i,
    output logic         b_o,
    output logic         b_oe,
    input  logic         xparent,
    input  logic         show,
    input  logic         keep_pol,
    output logic [W-1:0] drv
);

    logic [W-1:0] sr_q;
    logic [W-1:0] sr_nxt;
    logic [W-1:0] lat_view;
    pin_drv_t     pin_a;
    pin_drv_t     pin_b;

    sipo_shift_chain #(.W(W)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .fwd     (fwd),
        .in_low  (b_i),
        .in_high (a_i),
        .q       (sr_q),
        .nxt     (sr_nxt)
    );

    sipo_latch_stage #(.W(W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .xparent (xparent),
        .sr_q    (sr_q),
        .sr_nxt  (sr_nxt),
        .view    (lat_view)
    );

    sipo_out_stage #(.W(W)) u_out (
        .show     (show),
        .keep_pol (keep_pol),
        .lat      (lat_view),
        .drv      (drv)
    );

    // the pin not receiving data drives the stage leaving the register
    assign pin_a = '{data: sr_q[W-1], en: fwd};
    assign pin_b = '{data: sr_q[0],   en: ~fwd};

    assign a_o  = pin_a.data;
    assign a_oe = pin_a.en;
    assign b_o  = pin_b.data;
    assign b_oe = pin_b.en;

endmodule

// File: rtl/sipo_latch_driver_chk.sv
module sipo_latch_driver_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         fwd,
    input logic         a_i,
    input logic         a_o,
    input logic         a_oe,
    input logic         b_i,
    input logic         b_o,
    input logic         b_oe,
    input logic         xparent,
    input logic         show,
    input logic         keep_pol,
    input logic [W-1:0] sr_q,
    input logic [W-1:0] lat_view,
    input logic [W-1:0] drv
);

    // R2
    b_drives_chk: assert property (@(posedge clk) disable iff (rst)
        !fwd |-> (b_oe && !a_oe));

    // R3
    a_drives_chk: assert property (@(posedge clk) disable iff (rst)
        fwd |-> (a_oe && !b_oe));

    // R4
    down_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fwd)) |-> (sr_q == {$past(a_i), $past(sr_q[W-1:1])}));

    // R4
    up_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fwd)) |-> (sr_q == {$past(sr_q[W-2:0]), $past(b_i)}));

    // R11
    b_cascade_chk: assert property (@(posedge clk) disable iff (rst)
        (!fwd && !$past(fwd) && !$past(rst)) |-> (b_o == $past(sr_q[1])));

    // R11
    a_cascade_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd && $past(fwd) && !$past(rst)) |-> (a_o == $past(sr_q[W-2])));

    // R5
    open_follow_chk: assert property (@(posedge clk) disable iff (rst)
        xparent |-> (lat_view == sr_q));

    // R6
    closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!xparent && !$past(xparent) && !$past(rst)) |-> $stable(lat_view));

    // R9
    all_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!show && !keep_pol) |-> (drv == {W{1'b1}}));

    // R10
    all_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!show && keep_pol) |-> (drv == '0));

endmodule

bind sipo_latch_driver sipo_latch_driver_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fwd      (fwd),
    .a_i      (a_i),
    .a_o      (a_o),
    .a_oe     (a_oe),
    .b_i      (b_i),
    .b_o      (b_o),
    .b_oe     (b_oe),
    .xparent  (xparent),
    .show     (show),
    .keep_pol (keep_pol),
    .sr_q     (sr_q),
    .lat_view (lat_view),
    .drv      (drv)
);

// File: tb/sipo_latch_driver_test.sv
module sipo_latch_driver_test;

    localparam int unsigned W = 64;

    typedef struct packed {
        logic         show;
        logic         keep_pol;
        logic [63:0]  pat;
        logic [63:0]  expv;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF},
        '{1'b1, 1'b0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
        '{1'b0, 1'b0, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF},
        '{1'b0, 1'b1, 64'hFFFF0000F0F0AAAA, 64'h0000000000000000},
        '{1'b1, 1'b1, 64'hFFFF0000F0F0AAAA, 64'hFFFF0000F0F0AAAA},
        '{1'b1, 1'b0, 64'hFFFF0000F0F0AAAA, 64'h0000FFFF0F0F5555}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fwd = 1'b0;
    logic         a_i = 1'b0;
    logic         b_i = 1'b0;
    logic         xparent = 1'b0;
    logic         show = 1'b1;
    logic         keep_pol = 1'b1;
    logic         a_o, a_oe, b_o, b_oe;
    logic [W-1:0] drv;

    logic [W-1:0] m_sr  = '0;
    logic [W-1:0] m_lat = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sipo_latch_driver #(.W(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .fwd      (fwd),
        .a_i      (a_i),
        .a_o      (a_o),
        .a_oe     (a_oe),
        .b_i      (b_i),
        .b_o      (b_o),
        .b_oe     (b_oe),
        .xparent  (xparent),
        .show     (show),
        .keep_pol (keep_pol),
        .drv      (drv)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] mode_out(input logic s, input logic p,
                                             input logic [63:0] l);
        case ({s, p})
            2'b11:   return l;
            2'b10:   return ~l;
            2'b00:   return '1;
            default: return '0;
        endcase
    endfunction

    // one clock edge; the model follows the requirements
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_sr  = '0;
            m_lat = '0;
        end else begin
            if (fwd) m_sr = {m_sr[W-2:0], b_i};
            else     m_sr = {a_i, m_sr[W-1:1]};
            if (xparent) m_lat = m_sr;
        end
        @(negedge clk);
    endtask

    task automatic set_xp(input logic v);
        xparent = v;
        if (v) m_lat = m_sr;
    endtask

    // load a line going up; latch opens for the final edge only
    task automatic load_line(input logic [63:0] pat);
        fwd = 1'b1;
        for (int k = W - 1; k >= 0; k--) begin
            b_i = pat[k];
            if (k == 0) set_xp(1'b1);
            tick();
        end
        set_xp(1'b0);
        b_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check(drv == '0, "R1 channels after reset", drv, 64'd0);
        check({a_o, b_o} == 2'b00, "R1 serial outs after reset", {62'd0, a_o, b_o}, 64'd0);

        // R2 down direction with a marker bit
        set_xp(1'b1);
        fwd = 1'b0;
        a_i = 1'b1;
        tick();
        a_i = 1'b0;
        #1;
        check(drv == 64'h8000000000000000, "R2 entry at channel 64", drv, 64'h8000000000000000);
        check(b_oe && !a_oe, "R2 pin B driven", {62'd0, a_oe, b_oe}, 64'd1);
        for (int k = 0; k < 62; k++) tick();
        #1;
        check(b_o == 1'b0, "R11 marker not yet out", {63'd0, b_o}, 64'd0);
        tick();
        #1;
        check(b_o == 1'b1 && drv == 64'd1, "R11 marker out on B after 64 edges", drv, 64'd1);
        tick();
        #1;
        check(b_o == 1'b0, "R2 marker leaves", {63'd0, b_o}, 64'd0);

        // R3 up direction with a marker bit
        fwd = 1'b1;
        b_i = 1'b1;
        tick();
        b_i = 1'b0;
        #1;
        check(drv == 64'd1, "R3 entry at channel 1", drv, 64'd1);
        check(a_oe && !b_oe, "R3 pin A driven", {62'd0, a_oe, b_oe}, 64'd2);
        for (int k = 0; k < 63; k++) tick();
        #1;
        check(a_o == 1'b1 && drv == 64'h8000000000000000, "R3 marker out on A", drv,
              64'h8000000000000000);

        // R7 R8 R9 R10 vector table
        foreach (VECS[v]) begin
            show = 1'b1;
            keep_pol = 1'b1;
            load_line(VECS[v].pat);
            show = VECS[v].show;
            keep_pol = VECS[v].keep_pol;
            #1;
            check(drv == VECS[v].expv, "R7/R8 R9 R10 mode vector", drv, VECS[v].expv);
            check(drv == mode_out(show, keep_pol, m_lat), "R10 mode model", drv,
                  mode_out(show, keep_pol, m_lat));
        end

        // R6 hold while shifting, R4 shifting unaffected by controls
        show = 1'b1;
        keep_pol = 1'b1;
        load_line(64'hC3C3_5A5A_0F0F_9696);
        for (int k = 0; k < 20; k++) begin
            b_i = k[0] ^ k[2];
            show = k[1];
            keep_pol = k[3];
            tick();
            #1;
            check(a_o == m_sr[W-1], "R4 shifting independent of controls",
                  {63'd0, a_o}, {63'd0, m_sr[W-1]});
            check(drv == mode_out(show, keep_pol, 64'hC3C3_5A5A_0F0F_9696),
                  "R6 held line kept", drv, mode_out(show, keep_pol, 64'hC3C3_5A5A_0F0F_9696));
        end

        // R5 transparent latch follows each shift
        show = 1'b1;
        keep_pol = 1'b1;
        set_xp(1'b1);
        fwd = 1'b0;
        for (int k = 0; k < 8; k++) begin
            a_i = ~k[0];
            tick();
            #1;
            check(drv == m_sr, "R5 open latch follows", drv, m_sr);
        end
        set_xp(1'b0);

        // R1 reset clears a loaded latch
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        check(drv == '0, "R1 reset clears latch", drv, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule